// File: doc/BRIEF.md
# Granule Tag Check Unit

The unit decides whether a memory access may proceed by comparing the tag carried in its pointer against the allocation tags stored for the bytes it touches. Memory is split into 16-byte granules and each granule owns a 4-bit tag. Tags are packed two to a byte in a separate tag store. The unit reads that store through a synchronous read port with a latency of one cycle.

A request gives a start address, a length as size-minus-one and the pointer tag. The unit works out which granules and tag bytes the access covers. It fetches one tag byte per cycle and checks the nibbles that belong to the access. It stops at the first mismatch and then reports pass or fail together with the address of the fault. A bypass input marks the access as unchecked: the unit then answers at once with a pass and does not read the tag store. Page translation and fault delivery are handled by the logic around the unit.

Top module: `gtc_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o, pass_o, mem_req_o and fault_addr_o are all zero.
- R2: Granule g has its tag in tag byte g/2. Bits [3:0] hold the tag for even g and bits [7:4] the tag for odd g. The tag byte address is the byte address shifted right by 5, and address bit 4 picks the nibble.
- R3: The access covers granules floor(start/16) through floor((start+len_m1)/16), which is up to 17 tags for len_m1 = 255. The unit asserts mem_req_o on consecutive cycles. The first request goes to the first covered tag byte, and each later request goes to the next higher address. The unit never requests a byte outside the covered range.
- R4: The tag byte requested in one cycle is taken from mem_rdata_i in the next cycle.
- R5: When every covered tag equals ptr_tag_i, done_o pulses for one cycle B+1 cycles after the start edge, where B is the number of covered tag bytes, and pass_o is 1.
- R6: The lower nibble of the first byte is not checked when the start address has bit 4 set. The upper nibble of the last byte is not checked when it lies past the last covered granule.
- R7: On the first mismatch the check stops and done_o pulses in the cycle after that byte is taken in, with pass_o at 0. fault_addr_o is the start address when the first granule mismatches. Otherwise it is align16(start) + 16*n, where n is the number of granules that passed.
- R8: When start_i is accepted with bypass_i high, done_o and pass_o are 1 in the next cycle and no tag byte is requested.
- R9: A start_i that arrives while busy_o is high is ignored.
- R10: pass_o and fault_addr_o keep their values between completions. fault_addr_o is 0 after every passing completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a check; accepted only when idle |
| addr_i | input | ADDR_W | Start byte address of the access |
| len_m1_i | input | LEN_W | Access length minus one |
| ptr_tag_i | input | 4 | Tag carried by the pointer |
| bypass_i | input | 1 | Access is unchecked |
| busy_o | output | 1 | A check is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last completed check |
| fault_addr_o | output | ADDR_W | Fault address of the last failing check, else 0 |
| mem_req_o | output | 1 | Tag byte read request |
| mem_addr_o | output | ADDR_W-GRAN_LOG2-1 | Tag byte address |
| mem_rdata_i | input | 8 | Tag byte, one cycle after the request |

## Verification
The bench builds the unit with a 12-bit address, a 9-bit length and 16-byte granules. This gives a 128-byte tag store that a behavioural array models in full. With these values the longest access fits: 256 bytes starting mid-granule, which covers 17 tags over 9 bytes. The bench also drives accesses that start on an odd nibble and accesses that end on an even one. It places mismatches in the first granule, in the middle of an access and in the last granule. It checks that nibbles outside the access are ignored and that repeated start pulses during a check change nothing.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gtc_state_e;
endpackage

// File: rtl/gtc_span.sv
// Works out which granules and tag bytes an access covers.
module gtc_span #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 9,
  parameter int GRAN_LOG2 = 4,
  parameter int CNT_W     = 6,
  localparam int MEM_AW   = ADDR_W - GRAN_LOG2 - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  output logic [MEM_AW-1:0] first_byte_o,
  output logic [CNT_W-1:0]  tag_cnt_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              odd_o
);
  logic [LEN_W:0]   off_sum;
  logic [CNT_W-1:0] g_span;
  logic [CNT_W-1:0] b_span;

  always_comb begin
    off_sum      = {1'b0, len_m1_i} + (LEN_W+1)'(addr_i[GRAN_LOG2-1:0]);
    g_span       = CNT_W'(off_sum >> GRAN_LOG2);
    odd_o        = addr_i[GRAN_LOG2];
    b_span       = (CNT_W'(odd_o) + g_span) >> 1;
    tag_cnt_o    = g_span + CNT_W'(1);
    byte_cnt_o   = b_span + CNT_W'(1);
    first_byte_o = addr_i[ADDR_W-1:GRAN_LOG2+1];
  end
endmodule

// File: rtl/gtc_pair_cmp.sv
// Compares the two nibbles of one tag byte against the pointer tag.
module gtc_pair_cmp #(
  parameter int CNT_W = 6
) (
  input  logic [7:0]       data_i,
  input  logic [3:0]       tag_i,
  input  logic             skip_lo_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [1:0]       ok_cnt_o,
  output logic             miss_o,
  output logic             final_o
);
  logic [7:0] diff;
  logic       hi_en;

  always_comb begin
    diff     = data_i ^ {tag_i, tag_i};
    hi_en    = skip_lo_i ? (rem_i >= CNT_W'(1)) : (rem_i >= CNT_W'(2));
    ok_cnt_o = 2'd0;
    miss_o   = 1'b0;
    if (!skip_lo_i) begin
      if (diff[3:0] != 4'h0) begin
        miss_o = 1'b1;
      end else begin
        ok_cnt_o = 2'd1;
        if (hi_en) begin
          if (diff[7:4] != 4'h0) miss_o = 1'b1;
          else                   ok_cnt_o = 2'd2;
        end
      end
    end else if (hi_en) begin
      if (diff[7:4] != 4'h0) miss_o = 1'b1;
      else                   ok_cnt_o = 2'd1;
    end
    final_o = miss_o || (CNT_W'(ok_cnt_o) == rem_i);
  end
endmodule

// File: rtl/gtc_fetch.sv
// Issues back-to-back tag byte reads and tracks the one in flight.
module gtc_fetch #(
  parameter int MEM_AW = 27,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MEM_AW-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              run_i,
  output logic              req_o,
  output logic [MEM_AW-1:0] addr_o,
  output logic              pend_o
);
  logic [MEM_AW-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              pend_q;

  assign req_o  = run_i && (left_q != '0);
  assign addr_o = addr_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= req_o;
      if (load_i) begin
        addr_q <= base_i;
        left_q <= count_i;
      end else if (req_o) begin
        addr_q <= addr_q + MEM_AW'(1);
        left_q <= left_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/gtc_unit.sv
module gtc_unit #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 9,
  parameter int GRAN_LOG2 = 4,
  localparam int MEM_AW   = ADDR_W - GRAN_LOG2 - 1,
  localparam int CNT_W    = LEN_W - GRAN_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic [3:0]        ptr_tag_i,
  input  logic              bypass_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              mem_req_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i
);
  import gtc_pkg::*;

  gtc_state_e        state_q;
  logic [ADDR_W-1:0] start_q;
  logic [3:0]        tag_q;
  logic              skip_lo_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  n_ok_q;
  logic              done_q;
  logic              pass_q;
  logic [ADDR_W-1:0] fault_q;

  logic [MEM_AW-1:0] first_byte;
  logic [CNT_W-1:0]  tag_cnt;
  logic [CNT_W-1:0]  byte_cnt;
  logic              odd;
  logic              accept;
  logic              load;
  logic              pend;
  logic              consume;
  logic [1:0]        ok_cnt;
  logic              miss;
  logic              fin;
  logic [CNT_W-1:0]  n_sum;
  logic [ADDR_W-1:0] fault_calc;

  gtc_span #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GRAN_LOG2(GRAN_LOG2), .CNT_W(CNT_W)
  ) i_span (
    .addr_i      (addr_i),
    .len_m1_i    (len_m1_i),
    .first_byte_o(first_byte),
    .tag_cnt_o   (tag_cnt),
    .byte_cnt_o  (byte_cnt),
    .odd_o       (odd)
  );

  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && !bypass_i;

  gtc_fetch #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) i_fetch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .base_i (first_byte),
    .count_i(byte_cnt),
    .run_i  (state_q == ST_RUN),
    .req_o  (mem_req_o),
    .addr_o (mem_addr_o),
    .pend_o (pend)
  );

  gtc_pair_cmp #(.CNT_W(CNT_W)) i_cmp (
    .data_i   (mem_rdata_i),
    .tag_i    (tag_q),
    .skip_lo_i(skip_lo_q),
    .rem_i    (rem_q),
    .ok_cnt_o (ok_cnt),
    .miss_o   (miss),
    .final_o  (fin)
  );

  assign consume = (state_q == ST_RUN) && pend;

  always_comb begin
    n_sum = n_ok_q + CNT_W'(ok_cnt);
    if (n_sum == '0)
      fault_calc = start_q;
    else
      fault_calc = {start_q[ADDR_W-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}}
                 + (ADDR_W'(n_sum) << GRAN_LOG2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      start_q   <= '0;
      tag_q     <= '0;
      skip_lo_q <= 1'b0;
      rem_q     <= '0;
      n_ok_q    <= '0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fault_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (bypass_i) begin
          done_q  <= 1'b1;
          pass_q  <= 1'b1;
          fault_q <= '0;
        end else begin
          state_q   <= ST_RUN;
          start_q   <= addr_i;
          tag_q     <= ptr_tag_i;
          skip_lo_q <= odd;
          rem_q     <= tag_cnt;
          n_ok_q    <= '0;
        end
      end else if (consume) begin
        skip_lo_q <= 1'b0;
        rem_q     <= rem_q - CNT_W'(ok_cnt);
        n_ok_q    <= n_sum;
        if (fin) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pass_q  <= !miss;
          fault_q <= miss ? fault_calc : '0;
        end
      end
    end
  end

  assign busy_o       = (state_q == ST_RUN);
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fault_addr_o = fault_q;
endmodule

// File: rtl/gtc_unit_chk.sv
module gtc_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 9,
  parameter int GRAN_LOG2 = 4,
  localparam int MEM_AW   = ADDR_W - GRAN_LOG2 - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              bypass_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic              mem_req_o,
  input logic [MEM_AW-1:0] mem_addr_o
);
  p_req_when_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_req_ascending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + MEM_AW'(1)));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_bypass_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bypass_i && !busy_o) |=> (done_o && pass_o && !busy_o && !mem_req_o));

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(pass_o) && $stable(fault_addr_o)));

  p_pass_no_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (fault_addr_o == '0));
endmodule

bind gtc_unit gtc_unit_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GRAN_LOG2(GRAN_LOG2)
) i_gtc_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bypass_i    (bypass_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fault_addr_o(fault_addr_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/test_gtc_unit.sv
module test_gtc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int LW  = 9;
  localparam int GL  = 4;
  localparam int MAW = AW - GL - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [LW-1:0]  len_m1 = '0;
  logic [3:0]     ptag = '0;
  logic           byp = 1'b0;
  logic           busy, done, pass, mem_req;
  logic [AW-1:0]  fault;
  logic [MAW-1:0] mem_addr;
  logic [7:0]     mem_rdata = 8'h00;
  logic [7:0]     tmem [1<<MAW];

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  gtc_unit #(.ADDR_W(AW), .LEN_W(LW), .GRAN_LOG2(GL)) i_gtc_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .len_m1_i(len_m1), .ptr_tag_i(ptag), .bypass_i(byp),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fault_addr_o(fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tag store with one cycle of read latency (R4); garbage when not read.
  always @(posedge clk) mem_rdata <= mem_req ? tmem[mem_addr] : 8'hA5;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic set_tag(input int g, input logic [3:0] t);
    tmem[g>>1][(g&1)*4 +: 4] = t;
  endtask

  task automatic fill(input int g0, input int g1, input logic [3:0] t);
    for (int g = g0; g <= g1; g++) set_tag(g, t);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Reference: per-cycle expectations computed from the requirements.
  task automatic run_op(input int a, input int len, input int t, input bit bp,
                        input bit spam, input string rq);
    int fg, lg, cnt, k, b, j, dc, exp_fault, last_req, g, nib;
    bit ok;
    fg = a >> 4;
    lg = (a + len) >> 4;
    cnt = lg - fg + 1;
    b = (lg >> 1) - (fg >> 1) + 1;
    ok = 1;
    k = cnt;
    for (int i = 0; i < cnt; i++) begin
      g = fg + i;
      nib = (tmem[g>>1] >> ((g & 1) * 4)) & 15;
      if (nib != t) begin ok = 0; k = i; break; end
    end
    j = ok ? b - 1 : ((fg + k) >> 1) - (fg >> 1);
    exp_fault = ok ? 0 : (k == 0 ? a : ((fg + k) << 4) & ((1 << AW) - 1));
    if (bp) begin ok = 1; exp_fault = 0; end
    dc = bp ? 0 : j + 2;
    last_req = (b - 1 < j + 1) ? b - 1 : j + 1;

    @(negedge clk);
    addr = AW'(a); len_m1 = LW'(len); ptag = 4'(t); byp = bp; start = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= dc + 1; c++) begin
      @(negedge clk);
      if (spam && c < j + 1) begin
        start = 1'b1; addr = AW'(a ^ 12'h3F0); ptag = ~4'(t); byp = 1'b0;
      end else begin
        start = 1'b0; byp = 1'b0;
      end
      chk(bp ? "R8" : (spam ? "R9" : "R3"), "busy", int'(busy), (!bp && c <= j + 1) ? 1 : 0);
      chk(bp ? "R8" : "R3", "mem_req", int'(mem_req), (!bp && c <= last_req) ? 1 : 0);
      if (!bp && c <= last_req)
        chk("R2", "mem_addr", int'(mem_addr), (a >> 5) + c);
      chk(ok ? "R5" : "R7", "done", int'(done), (c == dc) ? 1 : 0);
      if (c >= dc) begin
        chk(rq, "pass", int'(pass), int'(ok));
        chk(c > dc ? "R10" : rq, "fault_addr", int'(fault), exp_fault);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    for (int i = 0; i < (1 << MAW); i++) tmem[i] = 8'((i * 37 + 11) & 255);
    #(CLK_PERIOD * 2 + 1);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "pass", int'(pass), 0);
    chk("R1", "mem_req", int'(mem_req), 0);
    chk("R1", "fault_addr", int'(fault), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after release", int'(busy), 0);
    chk("R1", "pass after release", int'(pass), 0);

    // R5: aligned single granule
    fill(0, 3, 4'h5);
    run_op('h000, 15, 5, 0, 0, "R5");
    // R6: odd start spanning two bytes
    run_op('h010, 31, 5, 0, 0, "R6");
    // R3: longest access, 17 tags over 9 bytes
    fill(16, 40, 4'h9);
    run_op('h108, 255, 9, 0, 0, "R3");
    // R7: first granule mismatch, fault = start
    fill(48, 51, 4'h3);
    run_op('h305, 20, 4, 0, 0, "R7");
    // R7: mid-access mismatch
    fill(64, 80, 4'h7);
    set_tag(69, 4'h2);
    run_op('h40C, 200, 7, 0, 0, "R7");
    // R7: mismatch in last granule
    fill(110, 113, 4'h1);
    set_tag(113, 4'h0);
    run_op('h6E0, 63, 1, 0, 0, "R7");
    // R6: upper nibble past the access ignored
    fill(96, 99, 4'h6);
    set_tag(97, 4'hE);
    run_op('h600, 15, 6, 0, 0, "R6");
    // R6: lower nibble before an odd start ignored
    set_tag(100, 4'hE);
    set_tag(101, 4'h6);
    run_op('h650, 15, 6, 0, 0, "R6");
    // R8: bypass over mismatching tags
    run_op('h305, 20, 4, 1, 0, "R8");
    // R9: start pulses while busy are ignored
    run_op('h40C, 200, 7, 0, 1, "R9");
    run_op('h108, 255, 9, 0, 1, "R9");
    // R10: back-to-back pass after fail clears fault
    run_op('h305, 20, 4, 0, 0, "R7");
    run_op('h000, 15, 5, 0, 0, "R10");
    summary();
  end
endmodule